// File: doc/BRIEF.md
# Flash read-timing checksum engine

This block walks a region of serial-flash memory one 32-bit word at a time and folds every word into a running checksum. Calibration firmware starts it once for each candidate pair of clock divisor and read-sample delay, then compares the resulting checksum against a known-good value to decide whether that pair reads the flash reliably.

A start pulse captures a start address, a byte length, a 4-bit divisor field and a delay field. The engine then issues word reads over a simple request/acknowledge port, adds each returned word and moves on. When no words remain it pulses done and presents the checksum. A built-in timing-window check overwrites the checksum with a fixed poison pattern when the captured divisor and delay pair is too aggressive. This lets a calibration sweep reject that pair at once.

Top module: `flash_cal_sum`

## Requirements
- R1: The checksum is the modulo-2^32 sum of every word read in one operation. The accumulator is cleared at each accepted start pulse.
- R2: Reads begin at the start address and step by 4 for each acknowledged word. While `rd_req_o` is high without `rd_ack_i`, the request and its address hold steady. An acknowledged read leaves `rd_req_o` high with the address raised by 4, or else ends the reads.
- R3: The byte length is rounded down to whole words (bits [1:0] are ignored). A length below 4 issues no read and completes with a checksum of 0, unless R5 to R7 force the poison value.
- R4: Divisor field values 4 to 15, and field value 0 (which encodes divisor 16), never force the poison value.
- R5: Divisor field 3 forces the poison value when the low three delay bits equal 0, and only then.
- R6: Divisor field 2 forces the poison value when the low three delay bits are below 2, and only then.
- R7: Divisor field 1 always forces the poison value, 32'h0BADC0DE, over the checksum.
- R8: The delay field is 4 bits wide. Bit 3 has no effect on the timing check.
- R9: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after an accepted start until `done_o` rises, and `done_o` is never high with `busy_o`. `sum_o` keeps its value until the next completion.
- R10: A start pulse that arrives while `busy_o` is high is ignored.
- R11: The divisor and delay fields are captured at start. Changing them during an operation has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| start_addr_i | input | ADDR_W | First word address |
| length_i | input | LEN_W | Region length in bytes |
| div_sel_i | input | 4 | Clock divisor field, 0 means 16 |
| dly_sel_i | input | DLY_W | Read-sample delay field |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | ADDR_W | Word read address |
| rd_ack_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 32 | Checksum or poison value |

## Verification
A wrong word counter shows at the read port straight away: there are too many or too few requests, or `done_o` comes early or late. A wrong address register shows on the first mismatching request. A corrupt accumulator, or a wrong decision in the timing window, appears only at the `done_o` pulse, in `sum_o`. For that reason every divisor class and delay boundary ends in its own comparison of `sum_o`. Missed or stuck control state shows within one cycle on `busy_o` and `done_o`, because the reference model follows both on every clock.

// File: rtl/flash_cal_sum.sv
module flash_cal_sum #(
  parameter int          ADDR_W = 32,
  parameter int          LEN_W  = 16,
  parameter int          DLY_W  = 4,
  parameter logic [31:0] POISON = 32'h0BADC0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  length_i,
  input  logic [3:0]        div_sel_i,
  input  logic [DLY_W-1:0]  dly_sel_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [31:0]       rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       sum_o
);
  localparam int WCNT_W = LEN_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_FIN} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic [31:0]       acc_q;
  logic [3:0]        div_q;
  logic [2:0]        dly_q;
  logic [WCNT_W-1:0] start_words;
  logic              timing_bad;
  logic              unused_hi_bits;

  assign start_words    = length_i[LEN_W-1:2];
  assign unused_hi_bits = ^{dly_sel_i[DLY_W-1:3], length_i[1:0]};

  assign timing_bad = (div_q == 4'd1) ||
                      (div_q == 4'd2 && dly_q < 3'd2) ||
                      (div_q == 4'd3 && dly_q == 3'd0);

  assign rd_req_o  = (state_q == S_READ);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wcnt_q  <= '0;
      acc_q   <= '0;
      div_q   <= '0;
      dly_q   <= '0;
      done_o  <= 1'b0;
      sum_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          addr_q  <= start_addr_i;
          wcnt_q  <= start_words;
          acc_q   <= '0;
          div_q   <= div_sel_i;
          dly_q   <= dly_sel_i[2:0];
          state_q <= (start_words == '0) ? S_FIN : S_READ;
        end
        S_READ: if (rd_ack_i) begin
          acc_q  <= acc_q + rd_data_i;
          addr_q <= addr_q + ADDR_W'(4);
          wcnt_q <= wcnt_q - WCNT_W'(1);
          if (wcnt_q == WCNT_W'(1)) state_q <= S_FIN;
        end
        S_FIN: begin
          sum_o   <= timing_bad ? POISON : acc_q;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cal_sum_chk.sv
module flash_cal_sum_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && rd_ack_i |=> !rd_req_o || rd_addr_o == $past(rd_addr_o) + ADDR_W'(4));
  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);
  a_r10_start_in_fin: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !rd_req_o && start_i |=> done_o && !busy_o);
endmodule

bind flash_cal_sum flash_cal_sum_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_flash_cal_sum.sv
module test_flash_cal_sum;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [15:0] length_i = '0;
  logic [3:0]  div_sel_i = '0;
  logic [3:0]  dly_sel_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [31:0] sum_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cal_sum i_flash_cal_sum (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h01234567;
  endfunction

  function automatic bit expect_poison(input logic [3:0] div, input logic [3:0] dly);
    int d;
    int low;
    d   = (div == 0) ? 16 : int'(div);
    low = int'(dly) % 8;
    if (d == 1) return 1'b1;
    if (d == 2) return low < 2;
    if (d == 3) return low < 1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] addr, input logic [15:0] len,
                        input logic [3:0] div, input logic [3:0] dly, input int lat, input bit glitch);
    logic [31:0] exp_addr;
    logic [31:0] exp_sum;
    logic [31:0] prev_sum;
    int words;
    int nreads;
    int wait_cnt;
    int iter;
    bit in_flight;
    exp_addr = addr;
    exp_sum  = 32'd0;
    words    = int'(len) / 4;
    nreads   = 0;
    wait_cnt = 0;
    iter     = 0;
    prev_sum = sum_o;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = addr; length_i = len; div_sel_i = div; dly_sel_i = dly;
    @(negedge clk);
    start_i = 1'b0;
    check("R9", {req, " busy after start"}, 32'(busy_o), 32'd1);
    check("R9", {req, " sum held while busy"}, sum_o, prev_sum);
    while (!done_o && iter < 2000) begin
      iter++;
      if (!busy_o) begin
        check("R9", {req, " busy until done"}, 32'(busy_o), 32'd1);
      end
      if (glitch && iter == 2) begin
        start_i = 1'b1; start_addr_i = 32'h00AB_0000; length_i = 16'd4;
        div_sel_i = 4'd1; dly_sel_i = 4'd0;
      end else begin
        start_i = 1'b0;
      end
      in_flight = rd_req_o;
      if (in_flight) begin
        if (rd_addr_o !== exp_addr) check("R2", {req, " read address"}, rd_addr_o, exp_addr);
        if (wait_cnt >= lat) begin
          rd_ack_i  = 1'b1;
          rd_data_i = mem_word(rd_addr_o);
          exp_sum   = exp_sum + mem_word(rd_addr_o);
          exp_addr  = exp_addr + 32'd4;
          nreads++;
          wait_cnt  = 0;
        end else begin
          rd_ack_i = 1'b0;
          wait_cnt++;
        end
      end else begin
        rd_ack_i = 1'b0;
      end
      @(negedge clk);
    end
    rd_ack_i = 1'b0;
    start_i  = 1'b0;
    if (expect_poison(div, dly)) exp_sum = 32'h0BADC0DE;
    check("R9", {req, " done seen"}, 32'(done_o), 32'd1);
    check("R9", {req, " busy low at done"}, 32'(busy_o), 32'd0);
    check("R3", {req, " read count"}, 32'(nreads), 32'(words));
    check(req, {req, " checksum"}, sum_o, exp_sum);
    @(negedge clk);
    check("R9", {req, " done single cycle"}, 32'(done_o), 32'd0);
    check("R9", {req, " sum held"}, sum_o, exp_sum);
    if (glitch) check("R10", {req, " no restart"}, 32'(busy_o), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "reset busy", 32'(busy_o), 32'd0);
    check("R9", "reset done", 32'(done_o), 32'd0);
    check("R2", "reset request", 32'(rd_req_o), 32'd0);
    check("R1", "reset sum", sum_o, 32'd0);

    run_op("R1", 32'h0000_1000, 16'd16, 4'd8, 4'd0, 0, 1'b0);
    run_op("R1", 32'hFFFF_FFF0, 16'd40, 4'd5, 4'd3, 1, 1'b0);
    run_op("R3", 32'h0000_2000, 16'd22, 4'd4, 4'd0, 2, 1'b0);
    run_op("R3", 32'h0000_2400, 16'd3,  4'd6, 4'd1, 0, 1'b0);
    run_op("R3", 32'h0000_2800, 16'd0,  4'd1, 4'd7, 0, 1'b0);
    run_op("R4", 32'h0000_3000, 16'd8,  4'd0, 4'd0, 0, 1'b0);
    run_op("R4", 32'h0000_3100, 16'd8,  4'd15, 4'd0, 1, 1'b0);
    run_op("R4", 32'h0000_3200, 16'd8,  4'd4, 4'd0, 0, 1'b0);
    run_op("R5", 32'h0000_4000, 16'd12, 4'd3, 4'd0, 0, 1'b0);
    run_op("R5", 32'h0000_4100, 16'd12, 4'd3, 4'd1, 0, 1'b0);
    run_op("R6", 32'h0000_5000, 16'd12, 4'd2, 4'd1, 1, 1'b0);
    run_op("R6", 32'h0000_5100, 16'd12, 4'd2, 4'd2, 0, 1'b0);
    run_op("R7", 32'h0000_6000, 16'd8,  4'd1, 4'd7, 0, 1'b0);
    run_op("R8", 32'h0000_7000, 16'd8,  4'd2, 4'd9, 0, 1'b0);
    run_op("R8", 32'h0000_7100, 16'd8,  4'd3, 4'd8, 0, 1'b0);
    run_op("R8", 32'h0000_7200, 16'd8,  4'd2, 4'd10, 0, 1'b0);
    run_op("R10", 32'h0000_8000, 16'd24, 4'd8, 4'd0, 1, 1'b1);
    run_op("R11", 32'h0000_9000, 16'd12, 4'd9, 4'd0, 0, 1'b1);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule